// File: doc/BRIEF.md
# Register-Fed Packet Transmitter

A processor fills this block one 32-bit word at a time through a small register bus, then commits the words as one packet by writing the packet size in bytes. Only committed packets are released to an AXI4-Stream master port, word by word in the order written, with TLAST marking the final word of each packet. Until the size write arrives, the words sit in a store-and-forward buffer and never reach the stream.

Software learns how much room is left by reading a vacancy register, which counts free word slots. Three sticky status bits in a shared status register report a finished packet, a push into a full buffer, and a size write that disagrees with the number of words pushed. A keyed write to a reset register flushes the whole transmit path. The buffer has `DEPTH` slots, of which `DEPTH - 4` are usable, so that is the largest packet.

Registers (byte offsets): 0x00 status, 0x08 reset key, 0x0C vacancy, 0x10 data, 0x14 size. Any other read returns zero.

Top module: `reg_stream_tx`

## Requirements
- R1: After reset the vacancy register (0x0C) reads `DEPTH - 4`, the status register (0x00) reads 0 and `m_tvalid` is low. Each write to the data register (0x10) that is accepted stores one word and lowers the vacancy by one.
- R2: Words that have not been committed never appear on the stream. A write to the size register (0x14) whose value is 4 times the number of uncommitted words commits them, and `m_tvalid` is high in the cycle that follows.
- R3: Committed words leave in the order they were written. `m_tlast` is high only on the word of index size/4 − 1 of each packet, and packets committed back to back stay separate.
- R4: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values into the next cycle.
- R5: Each word accepted on the stream (`m_tvalid` and `m_tready` both high at a clock edge) raises the vacancy by one.
- R6: Status bit 27 (packet done) is set after the beat that carries `m_tlast`. Writing the status register with bit 27 set clears it.
- R7: A size write that is zero, not a multiple of 4, or not 4 times the uncommitted word count sets status bit 25 (size mismatch), drops the uncommitted words (their vacancy comes back) and sends nothing. Writing the status register with bit 25 set clears it.
- R8: A data write while the vacancy is 0 is dropped and sets status bit 28 (overrun). Bit 28 is unaffected by status writes. While it is set, data writes and size writes have no effect.
- R9: Writing exactly 0x000000A5 to the reset register (0x08) empties the buffer, drops any committed packet, clears all status bits and lowers `m_tvalid`. Any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_waddr | input | ADDR_W | Byte offset of the register written |
| bus_wdata | input | 32 | Write value |
| bus_raddr | input | ADDR_W | Byte offset of the register read |
| bus_rdata | output | 32 | Read value, combinational from `bus_raddr` |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream word |
| m_tlast | output | 1 | Final word of a packet |

## Verification
Register reads are combinational, so the bench reads the vacancy and status registers in the same cycle it sets the read offset, and a register write is seen in the next cycle. A committed packet shows `m_tvalid` one clock after the size write; the vacancy moves one clock after each push or accepted beat, and status bits one clock after their event. The bench drives at the falling edge and samples shortly after it, so every check looks at the state left by the preceding rising edge and counts the beats it grants with `m_tready` itself.

// File: rtl/txp_pkg.sv
package txp_pkg;

  localparam int unsigned WORD_W = 32;

  // register byte offsets
  localparam logic [7:0] OFS_STATUS  = 8'h00;
  localparam logic [7:0] OFS_RESET   = 8'h08;
  localparam logic [7:0] OFS_VACANCY = 8'h0C;
  localparam logic [7:0] OFS_DATA    = 8'h10;
  localparam logic [7:0] OFS_SIZE    = 8'h14;

  localparam logic [WORD_W-1:0] RESET_KEY = 32'h0000_00A5;

  // status bit positions shared with the interrupt status word
  localparam int unsigned BIT_OVERRUN  = 28;
  localparam int unsigned BIT_DONE     = 27;
  localparam int unsigned BIT_MISMATCH = 25;

  typedef struct packed {
    logic overrun;
    logic done;
    logic mismatch;
  } txp_status_t;

  // a size write is good when it is a nonzero whole number of words
  // equal to the count of words waiting for commit
  function automatic logic size_matches(input logic [WORD_W-1:0] size_bytes,
                                        input logic [WORD_W-1:0] pending_words);
    return (size_bytes[1:0] == 2'b00) && (size_bytes != '0) &&
           ((size_bytes >> 2) == pending_words);
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input txp_status_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_OVERRUN]  = s.overrun;
    w[BIT_DONE]     = s.done;
    w[BIT_MISMATCH] = s.mismatch;
    return w;
  endfunction

endpackage

// File: rtl/txp_word_store.sv
module txp_word_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          mark_en,
  input  logic [AW-1:0] mark_idx,
  input  logic [AW-1:0] rd_idx,
  output logic [31:0]   rd_data,
  output logic          rd_last
);

  logic [31:0] mem [DEPTH];
  logic        last_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // end-of-packet flag per slot: cleared on a fresh push, set on commit
  for (genvar g = 0; g < DEPTH; g++) begin : g_last
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == AW'(g))) begin
        last_q[g] <= 1'b0;
      end else if (mark_en && (mark_idx == AW'(g))) begin
        last_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data = mem[rd_idx];
  assign rd_last = last_q[rd_idx];

endmodule

// File: rtl/txp_ptr_ctrl.sv
module txp_ptr_ctrl
  import txp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CAP  = DEPTH - 4,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          size_req,
  input  logic [31:0]   size_bytes,
  input  logic          flush,
  input  logic          beat,
  input  logic          beat_last,
  input  logic          clr_done,
  input  logic          clr_mismatch,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] commit_ptr,
  output logic [PW-1:0] vacancy,
  output logic          ev_push,
  output logic          ev_drop,
  output logic          ev_commit,
  output logic          ev_mismatch,
  output logic          ev_done,
  output txp_status_t   status
);

  logic [PW-1:0] occupancy;
  logic [PW-1:0] pending;
  logic          full;
  logic          size_ok;

  assign occupancy = wr_ptr - rd_ptr;
  assign pending   = wr_ptr - commit_ptr;
  assign full      = (occupancy == PW'(CAP));
  assign vacancy   = PW'(CAP) - occupancy;
  assign size_ok   = size_matches(size_bytes, 32'(pending));

  assign ev_push     = push_req && !status.overrun && !full;
  assign ev_drop     = push_req && !ev_push;
  assign ev_commit   = size_req && !status.overrun && size_ok;
  assign ev_mismatch = size_req && !status.overrun && !size_ok;
  assign ev_done     = beat && beat_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      commit_ptr <= '0;
    end else if (flush) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      commit_ptr <= '0;
    end else begin
      if (ev_push)     wr_ptr     <= wr_ptr + 1'b1;
      if (ev_mismatch) wr_ptr     <= commit_ptr;
      if (ev_commit)   commit_ptr <= wr_ptr;
      if (beat)        rd_ptr     <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (flush) begin
      status <= '0;
    end else begin
      status.overrun  <= status.overrun | ev_drop;
      status.done     <= (status.done & ~clr_done) | ev_done;
      status.mismatch <= (status.mismatch & ~clr_mismatch) | ev_mismatch;
    end
  end

endmodule

// File: rtl/reg_stream_tx.sv
module reg_stream_tx
  import txp_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [31:0]       bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [31:0]       bus_rdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [31:0]       m_tdata,
  output logic              m_tlast
);

  localparam int unsigned CAP = DEPTH - 4;
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned PW  = AW + 1;

  function automatic logic at_ofs(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // decoded bus events
  logic push_req, size_req, ev_key, clr_done, clr_mismatch;
  assign push_req     = bus_wr && at_ofs(bus_waddr, OFS_DATA);
  assign size_req     = bus_wr && at_ofs(bus_waddr, OFS_SIZE);
  assign ev_key       = bus_wr && at_ofs(bus_waddr, OFS_RESET) && (bus_wdata == RESET_KEY);
  assign clr_done     = bus_wr && at_ofs(bus_waddr, OFS_STATUS) && bus_wdata[BIT_DONE];
  assign clr_mismatch = bus_wr && at_ofs(bus_waddr, OFS_STATUS) && bus_wdata[BIT_MISMATCH];

  logic [PW-1:0] wr_ptr, rd_ptr, commit_ptr, vacancy;
  logic          ev_push, ev_drop, ev_commit, ev_mismatch, ev_done, ev_beat;
  txp_status_t   status;
  logic          sts_ovr, sts_done;
  logic [PW-1:0] last_ptr;

  assign ev_beat  = m_tvalid && m_tready;
  assign sts_ovr  = status.overrun;
  assign sts_done = status.done;
  assign last_ptr = wr_ptr - 1'b1;

  txp_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_req     (push_req),
    .size_req     (size_req),
    .size_bytes   (bus_wdata),
    .flush        (ev_key),
    .beat         (ev_beat),
    .beat_last    (m_tlast),
    .clr_done     (clr_done),
    .clr_mismatch (clr_mismatch),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .commit_ptr   (commit_ptr),
    .vacancy      (vacancy),
    .ev_push      (ev_push),
    .ev_drop      (ev_drop),
    .ev_commit    (ev_commit),
    .ev_mismatch  (ev_mismatch),
    .ev_done      (ev_done),
    .status       (status)
  );

  txp_word_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ev_push),
    .wr_idx   (wr_ptr[AW-1:0]),
    .wr_data  (bus_wdata),
    .mark_en  (ev_commit),
    .mark_idx (last_ptr[AW-1:0]),
    .rd_idx   (rd_ptr[AW-1:0]),
    .rd_data  (m_tdata),
    .rd_last  (m_tlast)
  );

  // a word is visible only once it lies below the commit point
  assign m_tvalid = (rd_ptr != commit_ptr);

  always_comb begin
    bus_rdata = '0;
    if (at_ofs(bus_raddr, OFS_STATUS))       bus_rdata = pack_status(status);
    else if (at_ofs(bus_raddr, OFS_VACANCY)) bus_rdata = 32'(vacancy);
  end

endmodule

// File: rtl/txp_checker.sv
module txp_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CAP  = DEPTH - 4,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic [31:0]   m_tdata,
  input logic          m_tlast,
  input logic          ev_push,
  input logic          ev_drop,
  input logic          ev_commit,
  input logic          ev_mismatch,
  input logic          ev_beat,
  input logic          ev_key,
  input logic          sts_ovr,
  input logic          sts_done,
  input logic [PW-1:0] vacancy
);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && !ev_key) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_push_vacancy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !ev_beat && !ev_key) |=> (vacancy == $past(vacancy) - 1'b1));

  assert_beat_vacancy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_beat && !ev_push && !ev_key && !ev_mismatch) |=> (vacancy == $past(vacancy) + 1'b1));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_beat && m_tlast && !ev_key) |=> sts_done);

  assert_drop_sets_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !ev_key) |=> sts_ovr);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ovr && !ev_key) |=> sts_ovr);

  assert_locked_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ovr |-> !ev_commit);

  assert_key_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_key |=> (!m_tvalid && !sts_ovr && (vacancy == PW'(CAP))));

endmodule

bind reg_stream_tx txp_checker #(.DEPTH(DEPTH)) u_txp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .m_tvalid    (m_tvalid),
  .m_tready    (m_tready),
  .m_tdata     (m_tdata),
  .m_tlast     (m_tlast),
  .ev_push     (ev_push),
  .ev_drop     (ev_drop),
  .ev_commit   (ev_commit),
  .ev_mismatch (ev_mismatch),
  .ev_beat     (ev_beat),
  .ev_key      (ev_key),
  .sts_ovr     (sts_ovr),
  .sts_done    (sts_done),
  .vacancy     (vacancy)
);

// File: tb/reg_stream_tx_bench.sv
module reg_stream_tx_bench;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned CAP   = DEPTH - 4;
  localparam logic [7:0] A_STS = 8'h00, A_RST = 8'h08, A_VAC = 8'h0C, A_DAT = 8'h10, A_SIZ = 8'h14;
  localparam logic [31:0] B_OVR = 32'h1000_0000, B_DONE = 32'h0800_0000, B_MIS = 32'h0200_0000;

  // vector table: {word count, first data value, tready pattern}
  localparam int NV = 4;
  localparam logic [47:0] VEC [NV] = '{
    {8'd1,  32'hA000_0000, 8'hFF},
    {8'd3,  32'h1111_0000, 8'h55},
    {8'd12, 32'h2222_0000, 8'h9B},
    {8'd5,  32'h3333_0000, 8'h01}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        m_tvalid, m_tlast;
  logic        m_tready = 1'b0;
  logic [31:0] m_tdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  reg_stream_tx #(.DEPTH(DEPTH), .ADDR_W(8)) u_reg_stream_tx (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic push_words(input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) bus_write(A_DAT, seed + 32'(i));
  endtask

  task automatic recv(input string req, input int n, input logic [31:0] seed,
                      input logic [7:0] mask);
    int idx = 0;
    int cyc = 0;
    logic held_v = 1'b0;
    logic [31:0] held_d = '0;
    while (idx < n && cyc < 400) begin
      @(negedge clk);
      m_tready = mask[cyc % 8];
      #1;
      if (held_v) check("R4", "held word", {m_tvalid, m_tdata[30:0]}, {1'b1, held_d[30:0]});
      if (m_tvalid && m_tready) begin
        check(req, "beat data", m_tdata, seed + 32'(idx));
        check("R3", "tlast", 32'(m_tlast), 32'(idx == n - 1));
        idx++;
      end
      held_v = m_tvalid && !m_tready;
      held_d = m_tdata;
      cyc++;
    end
    check(req, "beats received", 32'(idx), 32'(n));
    @(negedge clk);
    m_tready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_read(A_VAC, rd); check("R1", "reset vacancy", rd, 32'(CAP));
    bus_read(A_STS, rd); check("R1", "reset status", rd, 32'h0);
    check("R1", "reset tvalid", 32'(m_tvalid), 32'h0);

    // table of packets
    for (int v = 0; v < NV; v++) begin
      int n;
      logic [31:0] seed;
      n = int'(VEC[v][47:40]);
      seed = VEC[v][39:8];
      push_words(n, seed);
      bus_read(A_VAC, rd); check("R1", "vacancy after pushes", rd, 32'(CAP - n));
      bus_write(A_SIZ, 32'(4 * n));
      #1;
      check("R2", "tvalid after commit", 32'(m_tvalid), 32'h1);
      recv("R3", n, seed, VEC[v][7:0]);
      bus_read(A_VAC, rd); check("R5", "vacancy after drain", rd, 32'(CAP));
      bus_read(A_STS, rd); check("R6", "done set", rd, B_DONE);
      bus_write(A_STS, B_DONE);
      bus_read(A_STS, rd); check("R6", "done cleared", rd, 32'h0);
    end

    // uncommitted words stay inside
    push_words(2, 32'h7000_0000);
    m_tready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R2", "uncommitted not sent", 32'(m_tvalid), 32'h0);
    m_tready = 1'b0;
    bus_read(A_VAC, rd); check("R1", "vacancy two pending", rd, 32'(CAP - 2));

    // size mismatch cases
    bus_write(A_SIZ, 32'd12);
    bus_read(A_STS, rd); check("R7", "mismatch bit", rd, B_MIS);
    bus_read(A_VAC, rd); check("R7", "pending dropped", rd, 32'(CAP));
    check("R7", "nothing sent", 32'(m_tvalid), 32'h0);
    bus_write(A_STS, B_MIS);
    bus_read(A_STS, rd); check("R7", "mismatch cleared", rd, 32'h0);
    push_words(1, 32'h7100_0000);
    bus_write(A_SIZ, 32'd6);
    bus_read(A_STS, rd); check("R7", "non multiple of 4", rd, B_MIS);
    bus_read(A_VAC, rd); check("R7", "vacancy after bad size", rd, 32'(CAP));
    bus_write(A_STS, B_MIS);
    bus_write(A_SIZ, 32'd0);
    bus_read(A_STS, rd); check("R7", "zero size", rd, B_MIS);
    bus_write(A_STS, B_MIS);

    // vacancy rises per beat under stall
    push_words(3, 32'h8000_0000);
    bus_write(A_SIZ, 32'd12);
    bus_read(A_VAC, rd); check("R5", "vacancy before beat", rd, 32'(CAP - 3));
    m_tready = 1'b1;
    @(negedge clk);
    m_tready = 1'b0;
    bus_read(A_VAC, rd); check("R5", "vacancy after one beat", rd, 32'(CAP - 2));
    check("R3", "next word shown", m_tdata, 32'h8000_0001);
    recv("R3", 2, 32'h8000_0001, 8'hFF);
    bus_write(A_STS, B_DONE);

    // two packets committed back to back
    push_words(2, 32'h4000_0000);
    bus_write(A_SIZ, 32'd8);
    push_words(3, 32'h5000_0000);
    bus_write(A_SIZ, 32'd12);
    bus_read(A_VAC, rd); check("R1", "vacancy two packets", rd, 32'(CAP - 5));
    recv("R3", 2, 32'h4000_0000, 8'hFF);
    recv("R3", 3, 32'h5000_0000, 8'h6D);
    bus_write(A_STS, B_DONE);

    // overrun and lock
    push_words(CAP, 32'h6000_0000);
    bus_read(A_VAC, rd); check("R8", "full vacancy", rd, 32'h0);
    bus_write(A_DAT, 32'hDEAD_0000);
    bus_read(A_STS, rd); check("R8", "overrun set", rd, B_OVR);
    bus_write(A_STS, 32'hFFFF_FFFF);
    bus_read(A_STS, rd); check("R8", "overrun survives clear", rd, B_OVR);
    bus_write(A_SIZ, 32'(4 * CAP));
    #1;
    check("R8", "size ignored while locked", 32'(m_tvalid), 32'h0);
    bus_read(A_STS, rd); check("R8", "no mismatch while locked", rd, B_OVR);
    bus_write(A_RST, 32'h0000_005A);
    bus_read(A_STS, rd); check("R9", "wrong key no effect", rd, B_OVR);
    bus_read(A_VAC, rd); check("R9", "wrong key keeps data", rd, 32'h0);
    bus_write(A_RST, 32'h0000_00A5);
    bus_read(A_STS, rd); check("R9", "key clears status", rd, 32'h0);
    bus_read(A_VAC, rd); check("R9", "key empties buffer", rd, 32'(CAP));

    // key drops a committed packet
    push_words(3, 32'h9000_0000);
    bus_write(A_SIZ, 32'd12);
    #1;
    check("R2", "committed visible", 32'(m_tvalid), 32'h1);
    bus_write(A_RST, 32'h0000_00A5);
    #1;
    check("R9", "key lowers tvalid", 32'(m_tvalid), 32'h0);
    bus_read(A_VAC, rd); check("R9", "vacancy after key", rd, 32'(CAP));

    // path still works after the key
    push_words(2, 32'hB000_0000);
    bus_write(A_SIZ, 32'd8);
    recv("R2", 2, 32'hB000_0000, 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule